// File: doc/BRIEF.md
# Multi-Mode LUT Slice Element

This block is one table-plus-storage pair of a logic slice. A 16-bit store addressed by four select inputs is used in one of three ways: as the truth table of any 4-input function, as a 16x1 memory with asynchronous read and a write on the clock edge, or as a 16-bit shift register whose top bit cascades out. Beside the table sits a small carry unit. It forms a ripple carry from the two low select inputs and the carry input. In arithmetic mode it also turns the table output into a sum bit.

The combinational result then reaches a storage element. The element is either an edge-triggered flip-flop or a level-sensitive latch, and it can also be bypassed. Its set and clear controls each choose synchronous or asynchronous action and each choose an active level. Its data input can be inverted. The block is configured by static inputs and is meant to be tiled by a surrounding slice.

Top module: `lut_slice_cell`

## Requirements
- R1: In logic mode (cfg_mode_i = 0, or 3), comb_o equals cfg_table_i[addr_i], with addr_i read as an unsigned index (bit 0 the least significant).
- R2: In memory mode (cfg_mode_i = 1), comb_o is the stored bit at addr_i, with no clock delay. A rising edge with we_i high writes wd_i into that bit and leaves the other bits alone. The store tracks cfg_table_i on every edge spent in logic mode, so memory mode starts with that content.
- R3: In shift mode (cfg_mode_i = 2), each rising edge with we_i high moves every bit up one place and loads shin_i into bit 0. comb_o reads the bit at addr_i, and shout_o is bit 15. With we_i low, the contents hold.
- R4: cout_o always equals the majority of addr_i[0], addr_i[1] and cin_i.
- R5: With cfg_arith_i high, comb_o is the table bit XOR cin_i.
- R6: In flip-flop mode, q_o takes the storage input on a rising edge with ce_i high and holds when ce_i is low.
- R7: In latch mode, q_o follows the storage input while clk_i is high and ce_i is high, and holds while clk_i is low.
- R8: With cfg_inv_d_i high, the storage element captures the inverse of comb_o.
- R9: A synchronous set or clear acts on the rising edge whatever ce_i is, and not before that edge.
- R10: An asynchronous set or clear changes q_o at once, with no clock edge.
- R11: When set and clear are active together, the element is cleared.
- R12: With cfg_inv_set_i or cfg_inv_clr_i high, the matching control is active when its input is low.
- R13: With cfg_bypass_i high, q_o equals comb_o.
- R14: While rst_ni is low, the store, the flip-flop and the latch all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also the latch gate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Table select inputs |
| wd_i | input | 1 | Memory write data |
| we_i | input | 1 | Write enable in memory mode, shift enable in shift mode |
| shin_i | input | 1 | Shift data input |
| shout_o | output | 1 | Shift cascade output (bit 15) |
| cin_i | input | 1 | Carry input |
| cout_o | output | 1 | Carry output |
| ce_i | input | 1 | Storage clock enable |
| set_i | input | 1 | Storage set control |
| clr_i | input | 1 | Storage clear control |
| cfg_mode_i | input | 2 | 0 logic, 1 memory, 2 shift, 3 logic |
| cfg_table_i | input | 16 | Truth table contents |
| cfg_arith_i | input | 1 | Sum output enable |
| cfg_bypass_i | input | 1 | Route comb_o straight to q_o |
| cfg_latch_i | input | 1 | 1 latch, 0 flip-flop |
| cfg_sync_set_i | input | 1 | 1 synchronous set, 0 asynchronous |
| cfg_sync_clr_i | input | 1 | 1 synchronous clear, 0 asynchronous |
| cfg_inv_d_i | input | 1 | Invert storage data input |
| cfg_inv_set_i | input | 1 | Set active low |
| cfg_inv_clr_i | input | 1 | Clear active low |
| comb_o | output | 1 | Table or sum output |
| q_o | output | 1 | Slice output |

## Verification
The table read, the carry, the sum and the bypass path have no register. The bench checks them a fraction of a nanosecond after it drives the inputs, and asynchronous set and clear are checked the same way. Memory writes, shifts and flip-flop captures show up one rising edge later, so they are checked one nanosecond after that edge. Each synchronous control is also checked just before its edge, to show it has not yet acted. Latch transparency is checked within the clock-high phase, and latch hold is checked after the falling edge.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
  typedef enum logic [1:0] {
    MODE_LOGIC = 2'd0,
    MODE_RAM   = 2'd1,
    MODE_SHIFT = 2'd2,
    MODE_ALT   = 2'd3
  } lut_mode_e;
endpackage

// File: rtl/lut_store.sv
module lut_store
  import lut_slice_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lut_mode_e         mode_i,
  input  logic [DEPTH-1:0]  table_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              wd_i,
  input  logic              shin_i,
  output logic              rd_o,
  output logic              shout_o
);
  logic [DEPTH-1:0] mem_q;
  logic             use_mem;

  assign use_mem = (mode_i == MODE_RAM) || (mode_i == MODE_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      case (mode_i)
        MODE_RAM:   if (we_i) mem_q[addr_i] <= wd_i;
        MODE_SHIFT: if (we_i) mem_q <= {mem_q[DEPTH-2:0], shin_i};
        default:    mem_q <= table_i;  // preload for a later mode switch
      endcase
    end
  end

  assign rd_o    = use_mem ? mem_q[addr_i] : table_i[addr_i];
  assign shout_o = mem_q[DEPTH-1];

  assert_ram_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RAM && we_i) |=> mem_q[$past(addr_i)] == $past(wd_i));

  assert_ram_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RAM && !we_i) |=> $stable(mem_q));

  assert_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SHIFT && we_i) |=>
      (mem_q[0] == $past(shin_i)) && (mem_q[DEPTH-1:1] == $past(mem_q[DEPTH-2:0])));
endmodule

// File: rtl/slice_carry.sv
module slice_carry (
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  input  logic lut_i,
  input  logic arith_i,
  output logic sum_o,
  output logic cout_o
);
  logic prop;

  assign prop   = a_i ^ b_i;
  assign cout_o = (a_i & b_i) | (cin_i & prop);
  assign sum_o  = arith_i ? (lut_i ^ cin_i) : lut_i;
endmodule

// File: rtl/slice_reg.sv
module slice_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic ce_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic bypass_i,
  input  logic latch_i,
  input  logic sync_set_i,
  input  logic sync_clr_i,
  input  logic inv_d_i,
  input  logic inv_set_i,
  input  logic inv_clr_i,
  output logic q_o
);
  logic d_eff, set_eff, clr_eff;
  logic pre_a, clr_a, pre_s, clr_s;
  logic q_ff, q_lat;

  assign d_eff   = d_i ^ inv_d_i;
  assign set_eff = set_i ^ inv_set_i;
  assign clr_eff = clr_i ^ inv_clr_i;
  assign pre_a   = set_eff & ~sync_set_i;
  assign clr_a   = clr_eff & ~sync_clr_i;
  assign pre_s   = set_eff & sync_set_i;
  assign clr_s   = clr_eff & sync_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_a or posedge pre_a) begin
    if (!rst_ni)    q_ff <= 1'b0;
    else if (clr_a) q_ff <= 1'b0;
    else if (pre_a) q_ff <= 1'b1;
    else if (clr_s) q_ff <= 1'b0;
    else if (pre_s) q_ff <= 1'b1;
    else if (ce_i)  q_ff <= d_eff;
  end

  always_latch begin
    if (!rst_ni)     q_lat = 1'b0;
    else if (clr_a)  q_lat = 1'b0;
    else if (pre_a)  q_lat = 1'b1;
    else if (clk_i) begin
      if (clr_s)      q_lat = 1'b0;
      else if (pre_s) q_lat = 1'b1;
      else if (ce_i)  q_lat = d_eff;
    end
  end

  assign q_o = bypass_i ? d_i : (latch_i ? q_lat : q_ff);

  assert_ff_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && !set_eff && !clr_eff && sync_set_i && sync_clr_i) ##1
      (sync_set_i && sync_clr_i) |-> $stable(q_ff));

  assert_async_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_a |-> (q_ff == 1'b0));

  assert_clr_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_a && pre_a) |-> (q_ff == 1'b0) && (q_lat == 1'b0));
endmodule

// File: rtl/lut_slice_cell.sv
module lut_slice_cell
  import lut_slice_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wd_i,
  input  logic              we_i,
  input  logic              shin_i,
  output logic              shout_o,
  input  logic              cin_i,
  output logic              cout_o,
  input  logic              ce_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [DEPTH-1:0]  cfg_table_i,
  input  logic              cfg_arith_i,
  input  logic              cfg_bypass_i,
  input  logic              cfg_latch_i,
  input  logic              cfg_sync_set_i,
  input  logic              cfg_sync_clr_i,
  input  logic              cfg_inv_d_i,
  input  logic              cfg_inv_set_i,
  input  logic              cfg_inv_clr_i,
  output logic              comb_o,
  output logic              q_o
);
  lut_mode_e mode;
  logic      lut_rd, sum;

  assign mode = lut_mode_e'(cfg_mode_i);

  lut_store #(.ADDR_W(ADDR_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .table_i (cfg_table_i),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wd_i    (wd_i),
    .shin_i  (shin_i),
    .rd_o    (lut_rd),
    .shout_o (shout_o)
  );

  slice_carry u_carry (
    .a_i     (addr_i[0]),
    .b_i     (addr_i[1]),
    .cin_i   (cin_i),
    .lut_i   (lut_rd),
    .arith_i (cfg_arith_i),
    .sum_o   (sum),
    .cout_o  (cout_o)
  );

  slice_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .d_i        (sum),
    .ce_i       (ce_i),
    .set_i      (set_i),
    .clr_i      (clr_i),
    .bypass_i   (cfg_bypass_i),
    .latch_i    (cfg_latch_i),
    .sync_set_i (cfg_sync_set_i),
    .sync_clr_i (cfg_sync_clr_i),
    .inv_d_i    (cfg_inv_d_i),
    .inv_set_i  (cfg_inv_set_i),
    .inv_clr_i  (cfg_inv_clr_i),
    .q_o        (q_o)
  );

  assign comb_o = sum;
endmodule

// File: tb/sim_lut_slice_cell.sv
module sim_lut_slice_cell;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [3:0] addr = '0;
  logic wd = 0, we = 0, shin = 0, cin = 0, ce = 0, set_s = 0, clr_s = 0;
  logic [1:0] mode = 2'd0;
  logic [15:0] tbl = '0;
  logic arith = 0, bypass = 0, latch = 0, sync_set = 1, sync_clr = 1;
  logic inv_d = 0, inv_set = 0, inv_clr = 0;
  logic shout, cout, comb, q;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lut_slice_cell u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wd_i(wd), .we_i(we),
    .shin_i(shin), .shout_o(shout), .cin_i(cin), .cout_o(cout), .ce_i(ce),
    .set_i(set_s), .clr_i(clr_s), .cfg_mode_i(mode), .cfg_table_i(tbl),
    .cfg_arith_i(arith), .cfg_bypass_i(bypass), .cfg_latch_i(latch),
    .cfg_sync_set_i(sync_set), .cfg_sync_clr_i(sync_clr), .cfg_inv_d_i(inv_d),
    .cfg_inv_set_i(inv_set), .cfg_inv_clr_i(inv_clr), .comb_o(comb), .q_o(q)
  );

  typedef struct packed {
    logic [15:0] tbl;
    logic [3:0]  addr;
    logic        cin;
    logic        arith;
    logic        exp_comb;
    logic        exp_cout;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'h8000, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1},
    '{16'h8000, 4'h7, 1'b0, 1'b0, 1'b0, 1'b1},
    '{16'h6996, 4'h3, 1'b1, 1'b0, 1'b0, 1'b1},
    '{16'h6996, 4'h1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{16'hFFFE, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{16'hFFFE, 4'h2, 1'b0, 1'b1, 1'b1, 1'b0},
    '{16'h00FF, 4'h9, 1'b1, 1'b0, 1'b0, 1'b1},
    '{16'hA5A5, 4'h4, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R14 reset state
    step(); step();
    chk("R14 q in reset", q, 1'b0);
    chk("R14 shout in reset", shout, 1'b0);
    rst_ni = 1'b1;
    step();

    // R1 R4 R5 R13: vector walk in bypass
    bypass = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tbl = VECS[i].tbl; addr = VECS[i].addr; cin = VECS[i].cin; arith = VECS[i].arith;
      #0.5;
      chk(VECS[i].arith ? "R5 sum" : "R1 table read", comb, VECS[i].exp_comb);
      chk("R4 carry", cout, VECS[i].exp_cout);
      chk("R13 bypass", q, VECS[i].exp_comb);
    end
    bypass = 1'b0; arith = 1'b0; cin = 1'b0;
    step();

    // R2 memory mode
    tbl = 16'h1234; step();
    mode = 2'd1; addr = 4'd2; #0.5;
    chk("R2 preload read", comb, 1'b1);
    addr = 4'd5; wd = 1'b0; we = 1'b1; #0.5;
    chk("R2 before write", comb, 1'b1);
    step();
    chk("R2 written 0", comb, 1'b0);
    we = 1'b0; addr = 4'd4; #0.5;
    chk("R2 neighbour kept", comb, 1'b1);
    addr = 4'd5; wd = 1'b1; step();
    chk("R2 no write when we low", comb, 1'b0);
    we = 1'b1; step();
    chk("R2 written 1", comb, 1'b1);
    we = 1'b0;

    // R3 shift mode
    mode = 2'd0; tbl = 16'h0000; step();
    mode = 2'd2; we = 1'b1; shin = 1'b1; step();
    shin = 1'b0; addr = 4'd0; #0.5;
    chk("R3 bit0 loaded", comb, 1'b1);
    for (int k = 0; k < 14; k++) step();
    chk("R3 shout before bit15", shout, 1'b0);
    step();
    chk("R3 shout at bit15", shout, 1'b1);
    addr = 4'd15; #0.5;
    chk("R3 read bit15", comb, 1'b1);
    we = 1'b0; step();
    chk("R3 hold when we low", shout, 1'b1);

    // R6 flip-flop
    mode = 2'd0; tbl = 16'hFFFF; ce = 1'b1; step();
    chk("R6 capture", q, 1'b1);
    tbl = 16'h0000; ce = 1'b0; step();
    chk("R6 hold ce low", q, 1'b1);
    ce = 1'b1; step();
    chk("R6 capture 0", q, 1'b0);
    inv_d = 1'b1; step();
    chk("R8 inverted data", q, 1'b1);
    bypass = 1'b1; #0.5;
    chk("R13 bypass ignores inversion", q, 1'b0);
    bypass = 1'b0; inv_d = 1'b0; ce = 1'b0; #0.5;

    // R9 R11 synchronous controls
    clr_s = 1'b1; #0.5;
    chk("R9 clear waits for edge", q, 1'b1);
    step();
    chk("R9 sync clear with ce low", q, 1'b0);
    set_s = 1'b1; step();
    chk("R11 clear beats set sync", q, 1'b0);
    clr_s = 1'b0; #0.5;
    chk("R9 set waits for edge", q, 1'b0);
    step();
    chk("R9 sync set with ce low", q, 1'b1);
    set_s = 1'b0; step();

    // R10 R11 asynchronous controls
    sync_clr = 1'b0; sync_set = 1'b0; #0.5;
    clr_s = 1'b1; #0.5;
    chk("R10 async clear", q, 1'b0);
    clr_s = 1'b0; #0.5;
    set_s = 1'b1; #0.5;
    chk("R10 async set", q, 1'b1);
    clr_s = 1'b1; #0.5;
    chk("R11 clear beats set async", q, 1'b0);
    set_s = 1'b0; #0.3; clr_s = 1'b0;
    step();

    // R12 polarity
    inv_set = 1'b1; #0.5;
    chk("R12 set active low", q, 1'b1);
    set_s = 1'b1; #0.2;
    inv_clr = 1'b1; #0.5;
    chk("R12 clear active low", q, 1'b0);
    clr_s = 1'b1; #0.2;
    inv_set = 1'b0; inv_clr = 1'b0; set_s = 1'b0; clr_s = 1'b0;
    step();
    sync_set = 1'b1; sync_clr = 1'b1;
    step();

    // R7 latch
    latch = 1'b1; ce = 1'b1; tbl = 16'hFFFF;
    step();
    tbl = 16'h0000; #0.5;
    chk("R7 transparent low", q, 1'b0);
    tbl = 16'hFFFF; #0.5;
    chk("R7 transparent high", q, 1'b1);
    @(negedge clk); #0.5;
    tbl = 16'h0000; #0.5;
    chk("R7 hold while clk low", q, 1'b1);
    step();
    chk("R7 open again", q, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule